// File: doc/BRIEF.md
# Keyboard Pin Interrupt Controller

This block watches a group of keyboard input pins and raises one shared interrupt request toward the CPU. Each pin has its own enable bit. A disabled pin is ignored. An enabled pin is also reported to the port logic as a forced input, so its data direction setting no longer applies. Every pin passes through a two-flop synchronizer. A falling edge is a registered high followed by a current low on an enabled pin. The request then reaches the pending flag three clocks after the pin changes.

A mode bit picks the sensing style.

- **Edge mode** (mode bit clear): a falling edge sets the request. An acknowledge clears it at once. An acknowledge is either a write of the self-clearing acknowledge bit or the CPU's vector-fetch strobe.
- **Level mode** (mode bit set): a falling edge sets the request, and the request stays set while any enabled pin is low. It clears only after both of these have happened, in either order: an acknowledge, and the return of every enabled pin to high.

A mask bit gates the interrupt output. The pending flag shows the request whether or not the mask is set, so software can poll it. When the output is unmasked, the CPU services the request through the vector stored at 0xFFE0/0xFFE1.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: A falling edge on an enabled pin sets the pending flag on the third rising clock edge after the pin goes low. The pending flag is bit 3 of the control/status register at address 0.
- R2: In edge mode (bit 0 of address 0 is 0), an acknowledge clears the request on the next clock edge, even while the pin is still low. An acknowledge is either a write with bit 2 of address 0 set, or a one-cycle `vec_fetch` pulse.
- R3: In level mode (bit 0 of address 0 is 1), the request stays set after an acknowledge for as long as any enabled pin is low.
- R4: In level mode, the request clears only once an acknowledge has happened and all enabled pins are high, in either order. Pins returning high without an acknowledge leave it set.
- R5: `irq` equals the request gated by the mask bit (bit 1 of address 0; 1 means masked). The pending flag is not affected by the mask.
- R6: Reset clears the request, the mode bit, the mask bit and all enable bits, even while a pin is held low.
- R7: `dir_force` equals the enable register at address 1; bit i corresponds to pin i.
- R8: The acknowledge bit is write-only and always reads as 0. Reading address 0 returns {pending, 0, mask, mode} in bits 3..0.
- R9: A falling edge on a pin whose enable bit is 0 never sets the request. With no pin enabled, no request arises.
- R10: A falling edge in the same cycle as an acknowledge takes priority, and the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_in | input | NPINS | Raw keyboard pin levels |
| vec_fetch | input | 1 | CPU vector-fetch strobe for this interrupt, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 is control/status, 1 is enable |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Interrupt request to the CPU after the mask |
| dir_force | output | NPINS | Per-pin force-to-input for the port logic |

## Verification
The assertions check these properties on every cycle:
- a detected edge always leaves the request set on the next cycle, even when an acknowledge arrives in the same cycle;
- an acknowledge in edge mode clears the request;
- a low enabled pin in level mode keeps the request held;
- the mask forces `irq` low;
- no edge is detected while every pin is disabled.

Some behaviours can only be shown by the bench's scenarios:
- the three-cycle synchronizer latency;
- the two clearing orders in level mode;
- reset while a pin is held low;
- the read-back layout, including the acknowledge bit reading as zero;
- a disabled pin being ignored.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int KBD_MAXW = 32;

  typedef enum logic { MODE_EDGE = 1'b0, MODE_LEVEL = 1'b1 } kbd_mode_e;

  // 1 when every enabled pin reads high; disabled pins count as high
  function automatic logic kbd_all_high(input logic [KBD_MAXW-1:0] lvl,
                                        input logic [KBD_MAXW-1:0] en);
    return &(lvl | ~en);
  endfunction

  // 1 when some enabled pin went from high (previous) to low (current)
  function automatic logic kbd_any_fall(input logic [KBD_MAXW-1:0] prev,
                                        input logic [KBD_MAXW-1:0] cur,
                                        input logic [KBD_MAXW-1:0] en);
    return |(prev & ~cur & en);
  endfunction
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage1_q, stage2_q;

  // Pins idle high, so both stages reset to ones and no edge appears after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign q_out = stage2_q;
endmodule

// File: rtl/kbd_edge_det.sv
module kbd_edge_det
  import kbd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  output logic         fall,
  output logic         all_high
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  assign fall     = kbd_any_fall(KBD_MAXW'(prev_q), KBD_MAXW'(lvl), KBD_MAXW'(en));
  assign all_high = kbd_all_high(KBD_MAXW'(lvl), KBD_MAXW'(en));
endmodule

// File: rtl/kbd_req_fsm.sv
module kbd_req_fsm
  import kbd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  kbd_mode_e mode,
  input  logic      fall,
  input  logic      all_high,
  input  logic      ack,
  output logic      req,
  output logic      acked
);
  logic req_q, acked_q;
  logic acked_next;

  assign acked_next = acked_q | ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      acked_q <= 1'b0;
    end else if (fall) begin
      // a new edge wins over any acknowledge in the same cycle
      req_q   <= 1'b1;
      acked_q <= 1'b0;
    end else if (!req_q) begin
      acked_q <= 1'b0;
    end else if (mode == MODE_EDGE) begin
      if (ack) req_q <= 1'b0;
      acked_q <= 1'b0;
    end else if (acked_next && all_high) begin
      req_q   <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      acked_q <= acked_next;
    end
  end

  assign req   = req_q;
  assign acked = acked_q;
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl
  import kbd_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_in,
  input  logic              vec_fetch,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic [NPINS-1:0]  dir_force
);
  localparam int BIT_MODE = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_PEND = 3;

  kbd_mode_e        mode_q;
  logic             mask_q;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pins_sync;
  logic             fall_w, all_high_w, ack_w, req_w, acked_w;
  logic             wr_ctrl, wr_en_reg;

  assign wr_ctrl   = wr_en && (wr_addr == 1'b0);
  assign wr_en_reg = wr_en && (wr_addr == 1'b1);
  assign ack_w     = (wr_ctrl && wr_data[BIT_ACK]) || vec_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_EDGE;
      mask_q <= 1'b0;
      en_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= kbd_mode_e'(wr_data[BIT_MODE]);
        mask_q <= wr_data[BIT_MASK];
      end
      if (wr_en_reg) en_q <= wr_data[NPINS-1:0];
    end
  end

  kbd_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pins_in), .q_out(pins_sync)
  );

  kbd_edge_det #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_sync), .en(en_q),
    .fall(fall_w), .all_high(all_high_w)
  );

  kbd_req_fsm u_req (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .fall(fall_w),
    .all_high(all_high_w), .ack(ack_w), .req(req_w), .acked(acked_w)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == 1'b0) begin
      rd_data[BIT_MODE] = (mode_q == MODE_LEVEL);
      rd_data[BIT_MASK] = mask_q;
      rd_data[BIT_PEND] = req_w;
    end else begin
      rd_data = DATA_W'(en_q);
    end
  end

  assign irq       = req_w && !mask_q;
  assign dir_force = en_q;
endmodule

// File: rtl/kbd_irq_chk.sv
module kbd_irq_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             level_mode,
  input logic             mask,
  input logic             fall,
  input logic             all_high,
  input logic             ack,
  input logic             req,
  input logic             irq,
  input logic [NPINS-1:0] en
);
  // R1, R10: a detected edge leaves the request set, whatever else happens
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> req);

  // R2: edge mode acknowledge clears at once
  a_r2_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && req && ack && !fall) |=> !req);

  // R3: level mode holds while an enabled pin is low
  a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && req && !all_high) |=> req);

  // R4: level mode never clears without an acknowledge in that cycle or before
  a_r4_no_clear_unacked: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && req && !ack && $rose(req)) |=> req);

  // R5: the mask forces the output low
  a_r5_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);

  // R9: no edge is seen with every pin disabled
  a_r9_no_enable_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !fall);
endmodule

bind kbd_irq_ctrl kbd_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .level_mode(mode_q == kbd_pkg::MODE_LEVEL),
  .mask(mask_q), .fall(fall_w), .all_high(all_high_w), .ack(ack_w),
  .req(req_w), .irq(irq), .en(en_q)
);

// File: tb/sim_kbd_irq_ctrl.sv
module sim_kbd_irq_ctrl;
  localparam int NP = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '1;
  logic          vec_fetch = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_addr = 1'b0;
  logic [DW-1:0] rd_data;
  logic          irq;
  logic [NP-1:0] dir_force;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kbd_irq_ctrl #(.NPINS(NP), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .vec_fetch(vec_fetch),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .dir_force(dir_force)
  );

  // scoreboard item: which output to look at and the value expected there
  typedef enum int { SEL_PEND, SEL_IRQ, SEL_RD0, SEL_RD1, SEL_DIR } sel_e;
  typedef struct {
    string tag;
    sel_e  sel;
    int    exp;
  } item_t;
  item_t exp_q[$];

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        item_t it;
        int act;
        it = exp_q.pop_front();
        case (it.sel)
          SEL_PEND: act = int'(rd_data[3]);
          SEL_IRQ:  act = int'(irq);
          SEL_RD0, SEL_RD1: act = int'(rd_data);
          default:  act = int'(dir_force);
        endcase
        n_chk++;
        if (act != it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_val(input string tag, input sel_e sel, input int exp);
    item_t it;
    rd_addr = (sel == SEL_RD1);
    #1;
    it.tag = tag;
    it.sel = sel;
    it.exp = exp;
    exp_q.push_back(it);
    #1;
    rd_addr = 1'b0;
  endtask

  task automatic reg_write(input logic a, input logic [DW-1:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic fetch_pulse();
    vec_fetch = 1'b1;
    tick(1);
    vec_fetch = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    rst_n = 1'b1;
    tick(1);
    expect_val("R6 reset status", SEL_RD0, 0);
    expect_val("R6 reset irq", SEL_IRQ, 0);
    expect_val("R6 reset dir", SEL_DIR, 0);

    reg_write(1'b1, 8'h0F);
    expect_val("R7 enable readback", SEL_RD1, 'h0F);
    expect_val("R7 dir_force", SEL_DIR, 'h0F);

    // disabled pin 5 falls
    pins[5] = 1'b0;
    tick(4);
    expect_val("R9 disabled pin ignored", SEL_PEND, 0);
    pins[5] = 1'b1;
    tick(3);

    // edge mode, software acknowledge
    pins[1] = 1'b0;
    tick(2);
    expect_val("R1 not yet after two clocks", SEL_PEND, 0);
    tick(1);
    expect_val("R1 pending after three clocks", SEL_PEND, 1);
    expect_val("R5 irq unmasked", SEL_IRQ, 1);
    reg_write(1'b0, 8'h04);
    expect_val("R2 sw ack clears with pin low", SEL_PEND, 0);
    expect_val("R8 ack reads zero", SEL_RD0, 0);
    pins[1] = 1'b1;
    tick(3);

    // edge mode, vector fetch
    pins[2] = 1'b0;
    tick(3);
    expect_val("R1 pending pin2", SEL_PEND, 1);
    fetch_pulse();
    expect_val("R2 vec fetch clears", SEL_PEND, 0);
    pins[2] = 1'b1;
    tick(3);

    // mask
    reg_write(1'b0, 8'h02);
    pins[0] = 1'b0;
    tick(3);
    expect_val("R5 pending while masked", SEL_PEND, 1);
    expect_val("R5 irq masked", SEL_IRQ, 0);
    expect_val("R8 status layout", SEL_RD0, 'h0A);
    reg_write(1'b0, 8'h00);
    expect_val("R5 irq after unmask", SEL_IRQ, 1);
    reg_write(1'b0, 8'h04);
    expect_val("R2 cleared", SEL_PEND, 0);
    pins[0] = 1'b1;
    tick(3);

    // level mode, acknowledge first
    reg_write(1'b0, 8'h01);
    pins[3] = 1'b0;
    tick(3);
    expect_val("R1 level set", SEL_PEND, 1);
    reg_write(1'b0, 8'h05);
    expect_val("R3 held after ack", SEL_PEND, 1);
    tick(5);
    expect_val("R3 still held", SEL_PEND, 1);
    pins[3] = 1'b1;
    tick(2);
    expect_val("R4 sync latency", SEL_PEND, 1);
    tick(1);
    expect_val("R4 ack then high clears", SEL_PEND, 0);

    // level mode, pins high first
    pins[3] = 1'b0;
    tick(3);
    expect_val("R1 level set again", SEL_PEND, 1);
    pins[3] = 1'b1;
    tick(5);
    expect_val("R4 high without ack holds", SEL_PEND, 1);
    fetch_pulse();
    expect_val("R4 high then fetch clears", SEL_PEND, 0);

    // level mode, two pins low
    pins[0] = 1'b0;
    pins[1] = 1'b0;
    tick(3);
    reg_write(1'b0, 8'h05);
    pins[0] = 1'b1;
    tick(5);
    expect_val("R3 one pin still low", SEL_PEND, 1);
    pins[1] = 1'b1;
    tick(3);
    expect_val("R4 all high clears", SEL_PEND, 0);

    // edge in same cycle as acknowledge
    reg_write(1'b0, 8'h00);
    pins[0] = 1'b0;
    tick(3);
    pins[1] = 1'b0;
    tick(2);
    reg_write(1'b0, 8'h04);
    expect_val("R10 edge beats ack", SEL_PEND, 1);
    reg_write(1'b0, 8'h04);
    expect_val("R2 later ack clears", SEL_PEND, 0);
    pins[0] = 1'b1;
    pins[1] = 1'b1;
    tick(3);

    // reset with a pin held low in level mode
    reg_write(1'b0, 8'h03);
    pins[2] = 1'b0;
    tick(3);
    expect_val("R5 masked pending before reset", SEL_RD0, 'h0B);
    rst_n = 1'b0;
    tick(1);
    rst_n = 1'b1;
    tick(1);
    expect_val("R6 reset clears mode mask pending", SEL_RD0, 0);
    expect_val("R6 reset clears enable", SEL_RD1, 0);
    tick(4);
    expect_val("R9 nothing enabled", SEL_PEND, 0);
    pins[2] = 1'b1;

    wait (exp_q.size() == 0);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule